// File: doc/BRIEF.md
# Zero-Cross Synchronised Control Register Update Controller

This block sits between a serial control receiver and the analog switch controls of a two-channel audio path. Each received 44-bit control word arrives with a single-cycle load strobe, which marks the end of a transfer. The controller decides when the word's gain and selection fields reach the active left and right control registers. Applying them at the instant of a signal zero crossing keeps switching clicks out of the audio.

The word's own mode bits are captured at the load strobe. They choose between two update styles. In direct mode the word is written at once. In zero-cross mode it is held pending until a pulse arrives from one of four comparator tap points, and the word itself names that point. If no pulse comes, a no-signal timeout forces the pending word in. The controller also drives a select line that steers the shared comparator to the named point. Two routing bits send the update to the left register, the right register, or both. An external active-low mute forces the fader attenuation field to its infinite-attenuation code at the outputs, whatever the registers hold.

Top module: `zcu_top`

## Requirements
- R1: After reset both channel registers read zero, `busy_o` and `applied_o` are low, and `zc_point_o` is 0 (selector point).
- R2: When word bits 36 and 37 are both 1 (direct mode), the word is written on the load edge. `applied_o` is high in the following cycle, `busy_o` stays low, and any word still pending is discarded.
- R3: For any other value of bits 36/37 (zero-cross mode), the word is held pending. `busy_o` goes high in the cycle after the load, and the channel registers keep their values until the word is applied.
- R4: Bits {39,38} of the word name the detection point: 0 selector, 1 volume, 2 tone, 3 fader. `zc_point_o` shows the code from the cycle after the load. Only a pulse on that point's input applies a pending word, one cycle after the pulse, so one frame both sets the point and carries the data.
- R5: With no qualifying pulse, a pending word is applied max(L,1) cycles after its load edge, where L is `tmo_limit_i`.
- R6: A load while a word is pending replaces the pending word and restarts the timeout count from the new load.
- R7: Bits {33,32} route the update: 01 updates right only, 10 left only, 11 both, 00 neither.
- R8: Test and reserved bits 3, 20 to 23, 42 and 43 are ignored. The routing and mode bits 32, 33 and 36 to 39 are not stored either, so all of these read 0 in both channel outputs.
- R9: While `mute_n_i` is low, bits 31:28 (the fader field) of both outputs read 4'hF. Register contents are untouched and reappear when mute is released.
- R10: `applied_o` is a one-cycle pulse after each register update. A zero-cross pulse with nothing pending changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_i | input | 44 | Received control word |
| load_i | input | 1 | Single-cycle strobe marking a complete word |
| zc_sel_i | input | 1 | Zero-cross pulse, selector point |
| zc_vol_i | input | 1 | Zero-cross pulse, volume point |
| zc_tone_i | input | 1 | Zero-cross pulse, tone point |
| zc_fad_i | input | 1 | Zero-cross pulse, fader point |
| mute_n_i | input | 1 | External mute, active low |
| tmo_limit_i | input | TMR_W | No-signal timeout in cycles |
| left_o | output | 44 | Active left-channel control fields |
| right_o | output | 44 | Active right-channel control fields |
| zc_point_o | output | 2 | Comparator steering select |
| busy_o | output | 1 | A word is pending |
| applied_o | output | 1 | Registers were updated in the previous cycle |

## Verification
The bench builds the block with TMR_W = 6. This keeps every timeout value from 0 to 5 a few cycles long, so the exact cycle of the forced apply is checked for each limit, including the 0 and 1 boundary. With the short count, all sixteen pairings of named point and pulsing input are swept, along with all four routing codes and the replace-while-pending case. Each output is compared with a mask and channel model that the bench computes itself.

// File: rtl/zcu_pkg.sv
package zcu_pkg;
  localparam int WORD_W   = 44;
  localparam int CH_R_BIT = 32;
  localparam int CH_L_BIT = 33;
  localparam int MODE_LO  = 36;
  localparam int MODE_HI  = 37;
  localparam int PT_LO    = 38;
  localparam int PT_HI    = 39;
  localparam int FAD_LO   = 28;
  localparam int FAD_HI   = 31;
  // bits kept in channel registers: data fields only
  localparam logic [WORD_W-1:0] KEEP_MASK = 44'h30C_FF0F_FFF7;

  typedef enum logic [1:0] {
    PT_SEL  = 2'd0,
    PT_VOL  = 2'd1,
    PT_TONE = 2'd2,
    PT_FAD  = 2'd3
  } zc_point_e;
endpackage

// File: rtl/zcu_point_mux.sv
module zcu_point_mux
  import zcu_pkg::*;
(
  input  logic [3:0] zc_vec,
  input  zc_point_e  point,
  output logic       hit
);
  always_comb begin
    hit = zc_vec[point];
  end
endmodule

// File: rtl/zcu_timeout.sv
module zcu_timeout #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             clear,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W:0]   cnt_inc;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    expire  = run && !restart && (cnt_inc >= {1'b0, limit});
    cnt_d   = cnt_q;
    if (restart || clear) begin
      cnt_d = '0;
    end else if (run) begin
      cnt_d = cnt_inc[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  AST_TMO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/zcu_chan_regs.sv
module zcu_chan_regs #(
  parameter int W     = 44,
  parameter int N_CH  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [N_CH-1:0]         ch_sel,
  input  logic [W-1:0]            wr_data,
  output logic [N_CH-1:0][W-1:0]  regs_q
);
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic          en;
    logic [W-1:0]  reg_d;

    always_comb begin
      en    = wr_en && ch_sel[g];
      reg_d = en ? wr_data : regs_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else begin
        regs_q[g] <= reg_d;
      end
    end
  end
endmodule

// File: rtl/zcu_top.sv
module zcu_top
  import zcu_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [43:0]       word_i,
  input  logic              load_i,
  input  logic              zc_sel_i,
  input  logic              zc_vol_i,
  input  logic              zc_tone_i,
  input  logic              zc_fad_i,
  input  logic              mute_n_i,
  input  logic [TMR_W-1:0]  tmo_limit_i,
  output logic [43:0]       left_o,
  output logic [43:0]       right_o,
  output logic [1:0]        zc_point_o,
  output logic              busy_o,
  output logic              applied_o
);
  localparam int N_CH = 2;
  localparam int CH_R = 0;
  localparam int CH_L = 1;

  zc_point_e              point_q, point_d;
  logic                   busy_q, busy_d;
  logic                   applied_d;
  logic [WORD_W-1:0]      pend_q, pend_d;
  logic [N_CH-1:0]        pend_ch_q, pend_ch_d;
  logic                   load_direct, apply_pend, hit, expire;
  logic                   wr_en;
  logic [N_CH-1:0]        wr_ch;
  logic [WORD_W-1:0]      wr_data;
  logic [WORD_W-1:0]      word_kept;
  logic [N_CH-1:0]        word_ch;
  logic [N_CH-1:0][WORD_W-1:0] regs_q;

  zcu_point_mux u_mux (
    .zc_vec ({zc_fad_i, zc_tone_i, zc_vol_i, zc_sel_i}),
    .point  (point_q),
    .hit    (hit)
  );

  zcu_timeout #(.CNT_W(TMR_W)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (load_i),
    .clear   (apply_pend),
    .run     (busy_q),
    .limit   (tmo_limit_i),
    .expire  (expire)
  );

  always_comb begin
    word_kept   = word_i & KEEP_MASK;
    word_ch     = {word_i[CH_L_BIT], word_i[CH_R_BIT]};
    load_direct = load_i && word_i[MODE_LO] && word_i[MODE_HI];
    apply_pend  = busy_q && !load_i && (hit || expire);
    wr_en       = load_direct || apply_pend;
    wr_data     = load_direct ? word_kept : pend_q;
    wr_ch       = load_direct ? word_ch : pend_ch_q;
    applied_d   = wr_en;

    point_d   = point_q;
    busy_d    = busy_q;
    pend_d    = pend_q;
    pend_ch_d = pend_ch_q;
    if (load_i) begin
      point_d = zc_point_e'(word_i[PT_HI:PT_LO]);
      busy_d  = !load_direct;
      if (!load_direct) begin
        pend_d    = word_kept;
        pend_ch_d = word_ch;
      end
    end else if (apply_pend) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      point_q   <= PT_SEL;
      busy_q    <= 1'b0;
      applied_o <= 1'b0;
      pend_q    <= '0;
      pend_ch_q <= '0;
    end else begin
      point_q   <= point_d;
      busy_q    <= busy_d;
      applied_o <= applied_d;
      pend_q    <= pend_d;
      pend_ch_q <= pend_ch_d;
    end
  end

  zcu_chan_regs #(.W(WORD_W), .N_CH(N_CH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .ch_sel  (wr_ch),
    .wr_data (wr_data),
    .regs_q  (regs_q)
  );

  always_comb begin
    left_o  = regs_q[CH_L];
    right_o = regs_q[CH_R];
    if (!mute_n_i) begin
      left_o[FAD_HI:FAD_LO]  = '1;
      right_o[FAD_HI:FAD_LO] = '1;
    end
    zc_point_o = point_q;
    busy_o     = busy_q;
  end

  AST_DIRECT_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && word_i[MODE_LO] && word_i[MODE_HI]) |=> (applied_o && !busy_o)); // R2
  AST_ZC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !(word_i[MODE_LO] && word_i[MODE_HI])) |=> (busy_o && !applied_o)); // R3
  AST_IDLE_NO_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !load_i) |=> !applied_o); // R10
  AST_REGS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !applied_o |-> $stable(regs_q)); // R10
  AST_RESV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((regs_q[CH_L] | regs_q[CH_R]) & ~KEEP_MASK) == '0); // R8
  AST_MUTE_FADER: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_n_i |-> (left_o[FAD_HI:FAD_LO] == 4'hF && right_o[FAD_HI:FAD_LO] == 4'hF)); // R9
endmodule

// File: tb/zcu_top_tb.sv
module zcu_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TMR_W = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [43:0] word_i;
  logic        load_i;
  logic        zc_sel_i, zc_vol_i, zc_tone_i, zc_fad_i;
  logic        mute_n_i;
  logic [TMR_W-1:0] tmo_limit_i;
  logic [43:0] left_o, right_o;
  logic [1:0]  zc_point_o;
  logic        busy_o, applied_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [43:0] exp_l, exp_r;

  always #(CLK_PERIOD/2) clk = ~clk;

  zcu_top #(.TMR_W(TMR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .word_i(word_i), .load_i(load_i),
    .zc_sel_i(zc_sel_i), .zc_vol_i(zc_vol_i), .zc_tone_i(zc_tone_i),
    .zc_fad_i(zc_fad_i), .mute_n_i(mute_n_i), .tmo_limit_i(tmo_limit_i),
    .left_o(left_o), .right_o(right_o), .zc_point_o(zc_point_o),
    .busy_o(busy_o), .applied_o(applied_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // stored bits: 0-2, 4-19, 24-31, 34, 35, 40, 41 (R8)
  function automatic logic [43:0] kept(input logic [43:0] w);
    logic [43:0] r;
    for (int i = 0; i < 44; i++) begin
      bit k;
      k = (i < 32 && i != 3 && !(i >= 20 && i <= 23)) || i == 34 || i == 35 ||
          i == 40 || i == 41;
      r[i] = k ? w[i] : 1'b0;
    end
    return r;
  endfunction

  function automatic logic [43:0] mk(input int seed, input int ch, input int pt, input bit direct);
    logic [43:0] w;
    w = 44'h5A5_A5A5_A5A5 ^ (44'(seed) * 44'h1_2345_6789);
    w[3] = 1'b1; w[23:20] = 4'hF; w[43:42] = 2'b11;  // junk in ignored bits
    w[33:32] = 2'(ch);
    w[37:36] = direct ? 2'b11 : 2'b00;
    w[39:38] = 2'(pt);
    return w;
  endfunction

  task automatic route(input logic [43:0] w);
    if (w[33]) exp_l = kept(w);
    if (w[32]) exp_r = kept(w);
  endtask

  task automatic do_load(input logic [43:0] w);
    word_i = w; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic pulse(input int src);
    zc_sel_i = (src == 0); zc_vol_i = (src == 1);
    zc_tone_i = (src == 2); zc_fad_i = (src == 3);
    @(negedge clk);
    zc_sel_i = 0; zc_vol_i = 0; zc_tone_i = 0; zc_fad_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [43:0] w, wa;
    rst_n = 0; load_i = 0; word_i = '0; mute_n_i = 1;
    zc_sel_i = 0; zc_vol_i = 0; zc_tone_i = 0; zc_fad_i = 0;
    tmo_limit_i = 6'd63;
    exp_l = '0; exp_r = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 left", 64'(left_o), 64'h0);
    chk("R1 right", 64'(right_o), 64'h0);
    chk("R1 busy", 64'(busy_o), 64'h0);
    chk("R1 applied", 64'(applied_o), 64'h0);
    chk("R1 point", 64'(zc_point_o), 64'h0);

    // R10 pulse with nothing pending
    pulse(0);
    chk("R10 idle pulse applied", 64'(applied_o), 64'h0);
    chk("R10 idle pulse left", 64'(left_o), 64'(exp_l));

    // R2, R7, R8 direct mode over all routing codes
    for (int ch = 0; ch < 4; ch++) begin
      w = mk(ch + 1, ch, ch, 1'b1);
      do_load(w);
      route(w);
      chk("R2 applied", 64'(applied_o), 64'h1);
      chk("R2 busy", 64'(busy_o), 64'h0);
      chk("R7 R8 left", 64'(left_o), 64'(exp_l));
      chk("R7 R8 right", 64'(right_o), 64'(exp_r));
      @(negedge clk);
      chk("R10 one cycle", 64'(applied_o), 64'h0);
    end

    // R3, R4 zero-cross point sweep
    for (int pt = 0; pt < 4; pt++) begin
      for (int src = 0; src < 4; src++) begin
        w = mk(10 + pt * 4 + src, 3, pt, 1'b0);
        do_load(w);
        chk("R3 busy", 64'(busy_o), 64'h1);
        chk("R3 held left", 64'(left_o), 64'(exp_l));
        chk("R4 point", 64'(zc_point_o), 64'(pt));
        pulse(src);
        chk("R4 apply on point", 64'(applied_o), 64'(src == pt));
        if (src != pt) begin
          chk("R4 no apply left", 64'(left_o), 64'(exp_l));
          pulse(pt);
          chk("R4 late apply", 64'(applied_o), 64'h1);
        end
        route(w);
        chk("R4 left", 64'(left_o), 64'(exp_l));
        chk("R4 right", 64'(right_o), 64'(exp_r));
      end
    end

    // R5 timeout per limit
    for (int lim = 0; lim < 6; lim++) begin
      int lm;
      lm = (lim < 1) ? 1 : lim;
      tmo_limit_i = 6'(lim);
      w = mk(40 + lim, 2, 1, 1'b0);
      do_load(w);
      chk("R5 busy", 64'(busy_o), 64'h1);
      for (int k = 1; k <= lm; k++) begin
        @(negedge clk);
        chk("R5 applied timing", 64'(applied_o), 64'(k == lm));
      end
      route(w);
      chk("R5 left", 64'(left_o), 64'(exp_l));
      chk("R5 busy cleared", 64'(busy_o), 64'h0);
    end

    // R6 replace pending and restart timer
    tmo_limit_i = 6'd4;
    wa = mk(60, 3, 0, 1'b0);
    w  = mk(61, 1, 0, 1'b0);
    do_load(wa);
    do_load(w);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk("R6 restart timing", 64'(applied_o), 64'(k == 4));
    end
    route(w);
    chk("R6 left kept", 64'(left_o), 64'(exp_l));
    chk("R6 right replaced", 64'(right_o), 64'(exp_r));

    // R2 direct load discards pending
    tmo_limit_i = 6'd63;
    do_load(mk(70, 3, 0, 1'b0));
    w = mk(71, 2, 0, 1'b1);
    do_load(w);
    route(w);
    chk("R2 cancel busy", 64'(busy_o), 64'h0);
    pulse(0);
    chk("R2 cancel no apply", 64'(applied_o), 64'h0);
    chk("R2 cancel right", 64'(right_o), 64'(exp_r));

    // R9 mute
    mute_n_i = 0;
    @(negedge clk);
    chk("R9 left fader", 64'(left_o), 64'(exp_l | (44'hF << 28)));
    chk("R9 right fader", 64'(right_o), 64'(exp_r | (44'hF << 28)));
    mute_n_i = 1;
    @(negedge clk);
    chk("R9 released left", 64'(left_o), 64'(exp_l));

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule